// File: doc/BRIEF.md
# Event Status Channel Controller

This block holds the event state of a processing element: a 16-bit set of pending event bits, a 16-bit mask that chooses which events matter, and a single count bit that tells software a masked event can be read. Event sources (a decrementer underflow, a lost lock-line reservation, a stall notification and a general raise vector) set pending bits. Software writes the mask, acknowledges pending bits and reads the masked status through dedicated channel ports.

The count bit behaves like an edge flag. Any masked raise sets it, even when that bit is already pending. A status read clears the count and leaves the pending bits alone. A mask write or an acknowledge sets the count when masked pending bits remain afterwards. A status read issued while the count is 0 blocks: a stall output stays high until a masked event arrives, a wake pulse marks that arrival, and the read then completes. When the count is 1 and interrupts are enabled, the block takes an interrupt. It saves the address of the next instruction and turns interrupt enable off in the same step.

Top module: `evt_chan_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `chan_count`, `mask_rd`, `int_en`, `save_pc`, `stall`, `wake`, `irq`, `rd_valid` and `resv_held` are all 0, and no events are pending.
- R2: A raise ORs its bits into the pending set one clock later. If any raised bit is in the mask, `chan_count` becomes 1, even when that bit was already pending.
- R3: A mask write appears on `mask_rd` one clock later. `chan_count` is set if pending AND the new mask is nonzero. A raise of bits outside the mask leaves `chan_count` unchanged. A raise in the same cycle as a mask write is compared against the new mask.
- R4: An acknowledge clears the given bits from the pending set, and `chan_count` is set if pending AND mask is still nonzero. If a raise and an acknowledge hit the same bit in one cycle, the bit stays pending.
- R5: A status read made while `chan_count` is 1 gives `rd_valid` one clock later, with `rd_data` equal to pending AND mask. It clears `chan_count` and leaves the pending bits set.
- R6: A status read made while `chan_count` is 0 raises `stall` from the next clock on. The clock edge that brings a masked event also sets `wake` for one cycle. The read completes one clock after that edge, and `stall` falls at the same time.
- R7: `chan_count` is a single bit that reports readability. It is not a count of pending bits: several masked pending bits still read as 1.
- R8: When `chan_count` and `int_en` are both 1, the next clock gives a one-cycle `irq`, loads `save_pc` with `cur_pc + 4` and clears `int_en`. This interrupt take has priority over an enable write in the same cycle.
- R9: A `dec_underflow` pulse raises the timer event at bit 5.
- R10: `resv_lost` raises the lock-line event at bit 10 and clears `resv_held`, but only while a reservation is held. With no reservation held it raises nothing. `resv_acquire` sets `resv_held`.
- R11: `stall_note` raises the stall event at bit 1 only when no stall is outstanding, and it marks a stall outstanding. `stall_release` clears the outstanding stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_raise | input | 16 | General event raise vector, one pulse per bit |
| dec_underflow | input | 1 | Decrementer underflow pulse |
| resv_acquire | input | 1 | A lock-line reservation was taken |
| resv_lost | input | 1 | Reservation loss pulse |
| stall_note | input | 1 | Stall notification pulse |
| stall_release | input | 1 | Outstanding stall cleared |
| mask_we | input | 1 | Mask channel write strobe |
| mask_wdata | input | 16 | New mask value |
| ack_we | input | 1 | Acknowledge channel write strobe |
| ack_wdata | input | 16 | Bits to clear from the pending set |
| rd_req | input | 1 | Status read request pulse |
| rd_valid | output | 1 | Status read completed |
| rd_data | output | 16 | Masked status value |
| mask_rd | output | 16 | Current mask |
| chan_count | output | 1 | Channel count of the status channel |
| stall | output | 1 | A blocking read is waiting |
| wake | output | 1 | A masked event arrived while waiting |
| int_en_we | input | 1 | Interrupt enable write strobe |
| int_en_wdata | input | 1 | Interrupt enable value |
| cur_pc | input | 18 | Address of the current instruction |
| irq | output | 1 | Interrupt taken |
| save_pc | output | 18 | Saved return address |
| int_en | output | 1 | Interrupt enable |
| resv_held | output | 1 | A reservation is held |

## Verification
The bench sweeps every event bit, each with a two-bit mask and a raise that is only partly masked. It raises a bit that is already pending, and a design that set the count only on new bits would leave the count at 0 there. It acknowledges with an empty value after a read: a design that cleared the pending bits on the read would then show a count of 0 and no data. It also raises and acknowledges the same bit in one cycle, lets a blocking read wake, takes an interrupt, and sends a second stall note and a reservation loss with no reservation held. Each of these shows up as a wrong count, wrong data or a missing pulse on a design that got it wrong.

// File: rtl/evt_pkg.sv
// Shared constants for the event status channel controller.
// Assumes bit positions are below the event width.
package evt_pkg;
    localparam int EV_WIDTH_DEF  = 16;
    localparam int PC_WIDTH_DEF  = 18;
    localparam int STALL_BIT_DEF = 1;
    localparam int TIMER_BIT_DEF = 5;
    localparam int LOCK_BIT_DEF  = 10;
    localparam int PC_STEP       = 4;
endpackage

// File: rtl/evt_sources.sv
// Conditions the event sources into one raise vector.
// Tracks reservation-held and stall-outstanding state; inputs are single-cycle pulses.
module evt_sources #(
    parameter int EVW       = evt_pkg::EV_WIDTH_DEF,
    parameter int STALL_BIT = evt_pkg::STALL_BIT_DEF,
    parameter int TIMER_BIT = evt_pkg::TIMER_BIT_DEF,
    parameter int LOCK_BIT  = evt_pkg::LOCK_BIT_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_raise,
    input  logic           dec_underflow,
    input  logic           resv_acquire,
    input  logic           resv_lost,
    input  logic           stall_note,
    input  logic           stall_release,
    output logic [EVW-1:0] raise_all,
    output logic           resv_held
);
    logic stall_busy_q;
    logic resv_q;

    // Reservation tracking: loss wins over a same-cycle acquire.
    always_ff @(posedge clk) begin
        if (!rst_n)            resv_q <= 1'b0;
        else if (resv_lost)    resv_q <= 1'b0;
        else if (resv_acquire) resv_q <= 1'b1;
    end

    // Outstanding stall tracking: a note wins over a same-cycle release.
    always_ff @(posedge clk) begin
        if (!rst_n)             stall_busy_q <= 1'b0;
        else if (stall_note)    stall_busy_q <= 1'b1;
        else if (stall_release) stall_busy_q <= 1'b0;
    end

    // Merge all sources into one raise vector.
    always_comb begin
        raise_all = ev_raise;
        if (dec_underflow)              raise_all[TIMER_BIT] = 1'b1;
        if (resv_lost && resv_q)        raise_all[LOCK_BIT]  = 1'b1;
        if (stall_note && !stall_busy_q) raise_all[STALL_BIT] = 1'b1;
    end

    assign resv_held = resv_q;
endmodule

// File: rtl/evt_state.sv
// Holds pending bits, mask and the sticky channel count.
// Order inside a cycle: acknowledge, then raise (raise wins), read clears count, then set rules.
module evt_state #(
    parameter int EVW = evt_pkg::EV_WIDTH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] raise_all,
    input  logic           mask_we,
    input  logic [EVW-1:0] mask_wdata,
    input  logic           ack_we,
    input  logic [EVW-1:0] ack_wdata,
    input  logic           rd_fire,
    output logic [EVW-1:0] pending,
    output logic [EVW-1:0] mask,
    output logic           count,
    output logic           raise_hit
);
    logic [EVW-1:0] pend_q, mask_q, pend_n, mask_n, ack_bits;
    logic           count_q, count_n, still_live;

    // Next-state computation for pending, mask and count.
    always_comb begin
        ack_bits   = ack_we ? ack_wdata : '0;
        mask_n     = mask_we ? mask_wdata : mask_q;
        pend_n     = (pend_q & ~ack_bits) | raise_all;
        raise_hit  = |(raise_all & mask_n);
        still_live = |(pend_n & mask_n);
        count_n    = rd_fire ? 1'b0 : count_q;
        if ((mask_we || ack_we) && still_live) count_n = 1'b1;
        if (raise_hit)                         count_n = 1'b1;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= '0;
            count_q <= 1'b0;
        end else begin
            pend_q  <= pend_n;
            mask_q  <= mask_n;
            count_q <= count_n;
        end
    end

    assign pending = pend_q;
    assign mask    = mask_q;
    assign count   = count_q;
endmodule

// File: rtl/evt_reader.sv
// Status read port with blocking: a read at count 0 waits and stalls.
// Read data is the masked pending set of the cycle in which the read fires.
module evt_reader #(
    parameter int EVW = evt_pkg::EV_WIDTH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_req,
    input  logic           count,
    input  logic [EVW-1:0] pending,
    input  logic [EVW-1:0] mask,
    input  logic           raise_hit,
    output logic           rd_fire,
    output logic           rd_valid,
    output logic [EVW-1:0] rd_data,
    output logic           stall,
    output logic           wake
);
    logic           waiting_q, valid_q, wake_q;
    logic [EVW-1:0] data_q;

    assign rd_fire = (rd_req || waiting_q) && count;

    // Waiting flag, read result and wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            valid_q   <= 1'b0;
            data_q    <= '0;
            wake_q    <= 1'b0;
        end else begin
            valid_q <= rd_fire;
            wake_q  <= waiting_q && raise_hit;
            if (rd_fire) begin
                data_q    <= pending & mask;
                waiting_q <= 1'b0;
            end else if (rd_req) begin
                waiting_q <= 1'b1;
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_data  = data_q;
    assign stall    = waiting_q;
    assign wake     = wake_q;
endmodule

// File: rtl/evt_irq.sv
// Interrupt take: count and enable give a pulse, save next address, drop enable.
// The take wins over an enable write in the same cycle.
module evt_irq #(
    parameter int PCW = evt_pkg::PC_WIDTH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           count,
    input  logic           int_en_we,
    input  logic           int_en_wdata,
    input  logic [PCW-1:0] cur_pc,
    output logic           irq,
    output logic [PCW-1:0] save_pc,
    output logic           int_en
);
    localparam logic [PCW-1:0] STEP = PCW'(evt_pkg::PC_STEP);

    logic           en_q, irq_q, take;
    logic [PCW-1:0] save_q;

    assign take = count && en_q;

    // Enable, save register and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            irq_q  <= 1'b0;
            save_q <= '0;
        end else begin
            irq_q <= take;
            if (take) begin
                en_q   <= 1'b0;
                save_q <= cur_pc + STEP;
            end else if (int_en_we) begin
                en_q <= int_en_wdata;
            end
        end
    end

    assign irq     = irq_q;
    assign save_pc = save_q;
    assign int_en  = en_q;
endmodule

// File: rtl/evt_chan_ctrl.sv
// Top of the event status channel controller: sources, state, reader, interrupt.
// Assumes all strobes and source pulses are synchronous to clk.
module evt_chan_ctrl #(
    parameter int EVW = evt_pkg::EV_WIDTH_DEF,
    parameter int PCW = evt_pkg::PC_WIDTH_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] ev_raise,
    input  logic           dec_underflow,
    input  logic           resv_acquire,
    input  logic           resv_lost,
    input  logic           stall_note,
    input  logic           stall_release,
    input  logic           mask_we,
    input  logic [EVW-1:0] mask_wdata,
    input  logic           ack_we,
    input  logic [EVW-1:0] ack_wdata,
    input  logic           rd_req,
    output logic           rd_valid,
    output logic [EVW-1:0] rd_data,
    output logic [EVW-1:0] mask_rd,
    output logic           chan_count,
    output logic           stall,
    output logic           wake,
    input  logic           int_en_we,
    input  logic           int_en_wdata,
    input  logic [PCW-1:0] cur_pc,
    output logic           irq,
    output logic [PCW-1:0] save_pc,
    output logic           int_en,
    output logic           resv_held
);
    logic [EVW-1:0] raise_all, pending, mask;
    logic           count, raise_hit, rd_fire;

    evt_sources #(.EVW(EVW)) u_src (
        .clk(clk), .rst_n(rst_n), .ev_raise(ev_raise),
        .dec_underflow(dec_underflow), .resv_acquire(resv_acquire),
        .resv_lost(resv_lost), .stall_note(stall_note),
        .stall_release(stall_release), .raise_all(raise_all),
        .resv_held(resv_held)
    );

    evt_state #(.EVW(EVW)) u_state (
        .clk(clk), .rst_n(rst_n), .raise_all(raise_all),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .ack_we(ack_we), .ack_wdata(ack_wdata), .rd_fire(rd_fire),
        .pending(pending), .mask(mask), .count(count), .raise_hit(raise_hit)
    );

    evt_reader #(.EVW(EVW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .count(count),
        .pending(pending), .mask(mask), .raise_hit(raise_hit),
        .rd_fire(rd_fire), .rd_valid(rd_valid), .rd_data(rd_data),
        .stall(stall), .wake(wake)
    );

    evt_irq #(.PCW(PCW)) u_irq (
        .clk(clk), .rst_n(rst_n), .count(count),
        .int_en_we(int_en_we), .int_en_wdata(int_en_wdata),
        .cur_pc(cur_pc), .irq(irq), .save_pc(save_pc), .int_en(int_en)
    );

    assign mask_rd    = mask;
    assign chan_count = count;
endmodule

// File: rtl/evt_chan_ctrl_chk.sv
// Port-level temporal checks for the event status channel controller.
// Attached to every instance of the top by the bind below.
module evt_chan_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_valid,
    input logic chan_count,
    input logic stall,
    input logic wake,
    input logic irq,
    input logic int_en
);
    // R5: a completed read needs a readable count one cycle earlier
    a_r5_read_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(chan_count));

    // R6: the waiting flag falls only when its read completes
    a_r6_stall_drop_completes: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> rd_valid);

    // R6: a completed read leaves nothing waiting
    a_r6_no_stall_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !stall);

    // R6: a wake pulse always comes with a readable count
    a_r6_wake_with_count: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> chan_count);

    // R8: an interrupt follows count and enable, and leaves enable off
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(chan_count) && $past(int_en)));

    a_r8_irq_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !int_en);
endmodule

bind evt_chan_ctrl evt_chan_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .chan_count(chan_count),
    .stall(stall), .wake(wake), .irq(irq), .int_en(int_en)
);

// File: tb/evt_chan_ctrl_test.sv
// Self-checking bench: per-bit sweep plus directed corner cases.
module evt_chan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_raise = '0;
    logic        dec_underflow = 0, resv_acquire = 0, resv_lost = 0;
    logic        stall_note = 0, stall_release = 0;
    logic        mask_we = 0, ack_we = 0, rd_req = 0;
    logic [15:0] mask_wdata = '0, ack_wdata = '0;
    logic        int_en_we = 0, int_en_wdata = 0;
    logic [17:0] cur_pc = '0;
    logic        rd_valid, chan_count, stall, wake, irq, int_en, resv_held;
    logic [15:0] rd_data, mask_rd;
    logic [17:0] save_pc;

    int total = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    evt_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ev_raise(ev_raise),
        .dec_underflow(dec_underflow), .resv_acquire(resv_acquire),
        .resv_lost(resv_lost), .stall_note(stall_note),
        .stall_release(stall_release), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .ack_we(ack_we), .ack_wdata(ack_wdata),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .mask_rd(mask_rd), .chan_count(chan_count), .stall(stall),
        .wake(wake), .int_en_we(int_en_we), .int_en_wdata(int_en_wdata),
        .cur_pc(cur_pc), .irq(irq), .save_pc(save_pc), .int_en(int_en),
        .resv_held(resv_held)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_mask(input logic [15:0] m);
        mask_we = 1; mask_wdata = m; step(); mask_we = 0;
    endtask

    task automatic wr_ack(input logic [15:0] a);
        ack_we = 1; ack_wdata = a; step(); ack_we = 0;
    endtask

    task automatic raise(input logic [15:0] r);
        ev_raise = r; step(); ev_raise = '0;
    endtask

    task automatic do_read(input string req, input logic [15:0] exp);
        rd_req = 1; step(); rd_req = 0;
        check(req, {31'd0, rd_valid}, 32'd1);
        check(req, {16'd0, rd_data}, {16'd0, exp});
    endtask

    // Ack everything and drain the count so the next test starts clean.
    task automatic clean();
        wr_ack(16'hFFFF);
        if (chan_count) do_read("setup", rd_data & 16'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; total++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R1: reset state
        check("R1", {31'd0, chan_count}, 0);
        check("R1", {16'd0, mask_rd}, 0);
        check("R1", {31'd0, int_en}, 0);
        check("R1", {14'd0, save_pc}, 0);
        check("R1", {31'd0, stall}, 0);
        check("R1", {30'd0, rd_valid, resv_held}, 0);
        rst_n = 1; step();

        // Sweep every bit: partly masked raise, read, unmasked re-raise.
        for (int i = 0; i < 16; i++) begin
            logic [15:0] m, r, u;
            u = 16'(1) << ((i + 3) % 16);
            m = (16'(1) << i) | (16'(1) << ((i + 7) % 16));
            r = (16'(1) << i) | u;
            wr_mask(m);
            check("R3 mask", {16'd0, mask_rd}, {16'd0, m});
            raise(r);
            check("R2 count", {31'd0, chan_count}, 1);
            do_read("R5 data", r & m);
            check("R5 clear", {31'd0, chan_count}, 0);
            raise(u);
            check("R3 unmasked", {31'd0, chan_count}, 0);
            clean();
        end

        // R2: masked raise of an already pending bit sets count again
        wr_mask(16'h0001); raise(16'h0001); do_read("R2", 16'h0001);
        raise(16'h0001);
        check("R2 re-raise", {31'd0, chan_count}, 1);
        do_read("R2", 16'h0001);
        // R5/R4: read kept pending; empty ack recomputes count
        wr_ack(16'h0000);
        check("R4 recount", {31'd0, chan_count}, 1);
        do_read("R5 persist", 16'h0001);
        // R4: ack that leaves nothing masked does not set count
        wr_ack(16'h0001);
        check("R4 ack", {31'd0, chan_count}, 0);
        clean();

        // R4: raise and ack on one bit in one cycle, raise wins
        wr_mask(16'h0004);
        ev_raise = 16'h0004; ack_we = 1; ack_wdata = 16'h0004; step();
        ev_raise = '0; ack_we = 0;
        check("R4 raise wins", {31'd0, chan_count}, 1);
        do_read("R4 raise wins", 16'h0004);
        clean();

        // R3: mask write over pending bits sets count
        wr_mask(16'h0000); raise(16'h0F00);
        check("R3 no mask", {31'd0, chan_count}, 0);
        wr_mask(16'h0100);
        check("R3 mask set", {31'd0, chan_count}, 1);
        do_read("R3", 16'h0100);
        clean();

        // R7: many masked pending bits still report a count of 1
        wr_mask(16'hFFFF); raise(16'h00FF);
        check("R7", {31'd0, chan_count}, 1);
        do_read("R7", 16'h00FF);
        clean();

        // R6: blocking read woken by a masked event
        wr_mask(16'h0008);
        rd_req = 1; step(); rd_req = 0;
        check("R6 stall", {30'd0, stall, rd_valid}, 32'b10);
        step();
        check("R6 still", {31'd0, stall}, 1);
        raise(16'h0008);
        check("R6 wake", {29'd0, wake, chan_count, stall}, 32'b111);
        step();
        check("R6 done", {30'd0, rd_valid, stall}, 32'b10);
        check("R6 data", {16'd0, rd_data}, 32'h8);
        check("R6 wake pulse", {31'd0, wake}, 0);
        clean();

        // R8: interrupt take
        int_en_we = 1; int_en_wdata = 1; step(); int_en_we = 0;
        check("R8 enable", {31'd0, int_en}, 1);
        cur_pc = 18'h00100;
        wr_mask(16'h0002); raise(16'h0002);
        check("R8 pre", {31'd0, irq}, 0);
        step();
        check("R8 irq", {31'd0, irq}, 1);
        check("R8 save", {14'd0, save_pc}, 32'h104);
        check("R8 en off", {31'd0, int_en}, 0);
        step();
        check("R8 pulse", {31'd0, irq}, 0);
        clean();

        // R9: timer source
        wr_mask(16'h0020);
        dec_underflow = 1; step(); dec_underflow = 0;
        check("R9", {31'd0, chan_count}, 1);
        do_read("R9", 16'h0020);
        clean();

        // R10: lock-line loss with and without a reservation
        wr_mask(16'h0400);
        resv_lost = 1; step(); resv_lost = 0;
        check("R10 none held", {31'd0, chan_count}, 0);
        resv_acquire = 1; step(); resv_acquire = 0;
        check("R10 held", {31'd0, resv_held}, 1);
        resv_lost = 1; step(); resv_lost = 0;
        check("R10 lost", {30'd0, chan_count, resv_held}, 32'b10);
        do_read("R10", 16'h0400);
        clean();

        // R11: stall notification only when none outstanding
        wr_mask(16'h0002);
        stall_note = 1; step(); stall_note = 0;
        check("R11 first", {31'd0, chan_count}, 1);
        clean();
        stall_note = 1; step(); stall_note = 0;
        check("R11 repeat", {31'd0, chan_count}, 0);
        stall_release = 1; step(); stall_release = 0;
        stall_note = 1; step(); stall_note = 0;
        check("R11 after release", {31'd0, chan_count}, 1);
        do_read("R11", 16'h0002);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule